// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block gathers maskable interrupt requests from a configurable number of sources and presents a single interrupt request to the CPU. Each source has a 3-bit priority level that the CPU programs. A rising edge on a source input marks that source as pending. A pending source takes part in arbitration only when its level is between 1 and 6 and is not below the CPU's current 3-bit mask.

The highest qualifying level wins. When several sources share that level, the source with the lowest index wins, which is also the one with the smallest vector. The interrupt line, the winning level and the winning vector are combinational from the pending flags, the level registers and the mask input. When the CPU strobes a vector read, it takes the vector shown on the output, and the winning source's pending flag is cleared at the clock edge. Software can also clear any single pending flag by index.

Top module: `irqc_ctrl`

## Requirements
- R1: After reset, no source is pending and every level register holds 0. Until software programs a level, no request raises `irq_o`, even with the mask at 0.
- R2: A source whose level is 0 or 7 never wins arbitration and never causes `irq_o` to be asserted.
- R3: A pending source with a live level qualifies only when its level is greater than or equal to `cpu_mask_i`. A level equal to the mask qualifies.
- R4: Among qualifying sources, the one with the highest level wins.
- R5: When qualifying sources tie at the highest level, the lowest source index (the smallest vector) wins.
- R6: While `irq_o` is high, `irq_level_o` gives the winner's level and `vec_o` equals VEC_BASE + 4 × winner index, modulo 256, so bits 1:0 are always 00. While `irq_o` is low, `irq_level_o` is 0 and `vec_o` equals VEC_BASE.
- R7: When `vec_rd_i` is high while `irq_o` is high, the winner's pending flag is cleared at that clock edge and no other flag changes. The next winner then appears.
- R8: A pending flag is set by a 0-to-1 transition of its source input, sampled at the clock. A source held high does not set its flag again after the flag has been cleared.
- R9: A cycle with `clr_en_i` high clears the pending flag of source `clr_idx_i`.
- R10: If a rising edge and a clear (from a vector read or from software) hit the same source in the same cycle, the flag stays set.
- R11: With `cpu_mask_i` equal to 3'b111, which is the value the CPU holds after its reset, `irq_o` stays low whatever is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_req_i | input | NUM_SRC | Source request lines; a rising edge marks a source pending |
| lvl_wr_en_i | input | 1 | Level register write strobe |
| lvl_wr_idx_i | input | IDX_W | Source index for the level write |
| lvl_wr_data_i | input | 3 | New level value |
| clr_en_i | input | 1 | Software clear strobe |
| clr_idx_i | input | IDX_W | Source index to clear |
| cpu_mask_i | input | 3 | CPU interrupt mask level |
| vec_rd_i | input | 1 | Vector read strobe from the CPU |
| irq_o | output | 1 | Interrupt request toward the CPU |
| irq_level_o | output | 3 | Level of the winning source |
| vec_o | output | 8 | Vector of the winning source |

## Verification
The bench puts tied and mixed-level sets of requests against several mask values. A design that broke ties toward the higher index would return 0x48 where 0x44 is expected. A design that used a strict comparison against the mask would stay silent when the level equals the mask. It drives a new edge on a source in the same cycle that its flag is read out, and a design that let the clear win would lose that request. It also holds a source high across a software clear, which catches a design that latches the level of the input instead of its edge. Levels 0 and 7 are tested as disabled, and a design that treated only 0 as off would raise an interrupt for a level-7 source.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef logic [2:0] prio_t;

    localparam prio_t PRIO_OFF_LO = 3'd0;
    localparam prio_t PRIO_OFF_HI = 3'd7;

    // a level takes part in arbitration only strictly between the two off codes
    function automatic logic prio_live(prio_t p);
        return (p != PRIO_OFF_LO) && (p != PRIO_OFF_HI);
    endfunction

endpackage

// File: rtl/irqc_req_latch.sv
module irqc_req_latch #(
    parameter int N = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] src_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);

    typedef struct packed {
        logic [N-1:0] src;
        logic [N-1:0] pend;
    } latch_st_t;

    latch_st_t st_d, st_q;
    logic [N-1:0] rise;

    always_comb begin
        rise     = src_i & ~st_q.src;
        st_d     = st_q;
        st_d.src = src_i;
        // a fresh edge beats a clear in the same cycle
        st_d.pend = (st_q.pend & ~clr_i) | rise;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R8
        pend_set_by_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(pend_o[i]) |-> $past(src_i[i]));
        // R10
        edge_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (src_i[i] && !st_q.src[i]) |=> pend_o[i]);
        // R7
        clear_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_i[i] && !(src_i[i] && !st_q.src[i])) |=> !pend_o[i]);
    end

endmodule

// File: rtl/irqc_prio_regs.sv
module irqc_prio_regs
    import irqc_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [IW-1:0]     wr_idx_i,
    input  prio_t             wr_data_i,
    output prio_t [N-1:0]     prio_o
);

    typedef struct packed {
        prio_t [N-1:0] lvl;
    } prio_st_t;

    prio_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (wr_en_i && (wr_idx_i == IW'(i))) st_d.lvl[i] = wr_data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign prio_o = st_q.lvl;

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  pend_i,
    input  prio_t [N-1:0] prio_i,
    input  prio_t         mask_i,
    output logic          hit_o,
    output prio_t         lvl_o,
    output logic [IW-1:0] idx_o
);

    logic [N-1:0] elig;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            elig[i] = pend_i[i] && prio_live(prio_i[i]) && (prio_i[i] >= mask_i);
        end
    end

    // scan upward; only a strictly higher level displaces the holder,
    // so lower indices keep ties
    always_comb begin
        hit_o = 1'b0;
        lvl_o = PRIO_OFF_LO;
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && (!hit_o || (prio_i[i] > lvl_o))) begin
                hit_o = 1'b1;
                lvl_o = prio_i[i];
                idx_o = IW'(i);
            end
        end
    end

endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
    import irqc_pkg::*;
#(
    parameter int          NUM_SRC  = 8,
    parameter logic [7:0]  VEC_BASE = 8'h40,
    localparam int         IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_req_i,
    input  logic               lvl_wr_en_i,
    input  logic [IDX_W-1:0]   lvl_wr_idx_i,
    input  logic [2:0]         lvl_wr_data_i,
    input  logic               clr_en_i,
    input  logic [IDX_W-1:0]   clr_idx_i,
    input  logic [2:0]         cpu_mask_i,
    input  logic               vec_rd_i,
    output logic               irq_o,
    output logic [2:0]         irq_level_o,
    output logic [7:0]         vec_o
);

    localparam int VEC_STEP_SH = 2;

    prio_t [NUM_SRC-1:0] prio;
    logic  [NUM_SRC-1:0] pend;
    logic  [NUM_SRC-1:0] clr;
    logic                win_hit;
    prio_t               win_lvl;
    logic  [IDX_W-1:0]   win_idx;

    irqc_prio_regs #(.N(NUM_SRC), .IW(IDX_W)) prio_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (lvl_wr_en_i),
        .wr_idx_i  (lvl_wr_idx_i),
        .wr_data_i (prio_t'(lvl_wr_data_i)),
        .prio_o    (prio)
    );

    irqc_req_latch #(.N(NUM_SRC)) latch_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .src_i  (src_req_i),
        .clr_i  (clr),
        .pend_o (pend)
    );

    irqc_arbiter #(.N(NUM_SRC), .IW(IDX_W)) arb_i (
        .pend_i (pend),
        .prio_i (prio),
        .mask_i (prio_t'(cpu_mask_i)),
        .hit_o  (win_hit),
        .lvl_o  (win_lvl),
        .idx_o  (win_idx)
    );

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            clr[i] = (clr_en_i && (clr_idx_i == IDX_W'(i)))
                   || (vec_rd_i && win_hit && (win_idx == IDX_W'(i)));
        end
    end

    assign irq_o       = win_hit;
    assign irq_level_o = win_lvl;
    assign vec_o       = VEC_BASE + (8'(win_idx) << VEC_STEP_SH);

    // R3
    level_vs_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (irq_level_o >= cpu_mask_i));
    // R2
    live_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (irq_level_o != 3'd0 && irq_level_o != 3'd7));
    // R11
    full_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cpu_mask_i == 3'b111) |-> !irq_o);
    // R6
    vec_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_o[1:0] == 2'b00);
    // R6
    idle_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_o |-> (irq_level_o == 3'd0 && vec_o == VEC_BASE));

endmodule

// File: tb/irqc_ctrl_tb.sv
module irqc_ctrl_tb_top;

    localparam int         NS   = 8;
    localparam int         IW   = 3;
    localparam logic [7:0] BASE = 8'h40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src = '0;
    logic          lw_en = 1'b0;
    logic [IW-1:0] lw_idx = '0;
    logic [2:0]    lw_dat = '0;
    logic          c_en = 1'b0;
    logic [IW-1:0] c_idx = '0;
    logic [2:0]    mask = 3'b111;
    logic          vrd = 1'b0;
    logic          irq;
    logic [2:0]    lvl;
    logic [7:0]    vec;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    irqc_ctrl #(.NUM_SRC(NS), .VEC_BASE(BASE)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .src_req_i(src),
        .lvl_wr_en_i(lw_en), .lvl_wr_idx_i(lw_idx), .lvl_wr_data_i(lw_dat),
        .clr_en_i(c_en), .clr_idx_i(c_idx), .cpu_mask_i(mask),
        .vec_rd_i(vrd), .irq_o(irq), .irq_level_o(lvl), .vec_o(vec)
    );

    // fields: req[22:15] mask[14:12] irq[11] lvl[10:8] vec[7:0]
    localparam logic [22:0] TBL [10] = '{
        {8'h01, 3'd0, 1'b1, 3'd3, 8'h40},  // R6 single source
        {8'h06, 3'd0, 1'b1, 3'd5, 8'h44},  // R5 tie at 5
        {8'h18, 3'd0, 1'b0, 3'd0, 8'h40},  // R2 levels 0 and 7
        {8'hA0, 3'd6, 1'b1, 3'd6, 8'h54},  // R5 tie at 6, mask 6
        {8'h23, 3'd4, 1'b1, 3'd6, 8'h54},  // R4 highest level
        {8'h41, 3'd4, 1'b0, 3'd0, 8'h40},  // R3 below mask
        {8'h41, 3'd3, 1'b1, 3'd3, 8'h40},  // R3 equal to mask
        {8'hFF, 3'd7, 1'b0, 3'd0, 8'h40},  // R11 full mask
        {8'hFF, 3'd0, 1'b1, 3'd6, 8'h54},  // R4 all pending
        {8'h80, 3'd1, 1'b1, 3'd6, 8'h5C}   // R6 top index
    };

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse(logic [NS-1:0] m);
        src = m; step(); src = '0; step();
    endtask

    task automatic wr_lvl(int i, logic [2:0] v);
        lw_en = 1'b1; lw_idx = IW'(i); lw_dat = v; step(); lw_en = 1'b0;
    endtask

    task automatic clear_all();
        for (int i = 0; i < NS; i++) begin
            c_en = 1'b1; c_idx = IW'(i); step();
        end
        c_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        // R1 reset outputs and reset levels
        chk("R1 irq", {7'd0, irq}, 8'd0);
        chk("R1 lvl", {5'd0, lvl}, 8'd0);
        chk("R1 vec", vec, BASE);
        mask = 3'd0;
        pulse('1);
        chk("R1 unprogrammed levels", {7'd0, irq}, 8'd0);
        clear_all();

        wr_lvl(0, 3'd3); wr_lvl(1, 3'd5); wr_lvl(2, 3'd5); wr_lvl(3, 3'd0);
        wr_lvl(4, 3'd7); wr_lvl(5, 3'd6); wr_lvl(6, 3'd1); wr_lvl(7, 3'd6);

        for (int r = 0; r < 10; r++) begin
            mask = TBL[r][14:12];
            pulse(TBL[r][22:15]);
            chk($sformatf("R3/R4/R5 row%0d irq", r), {7'd0, irq}, {7'd0, TBL[r][11]});
            chk($sformatf("R6 row%0d lvl", r), {5'd0, lvl}, {5'd0, TBL[r][10:8]});
            chk($sformatf("R6 row%0d vec", r), vec, TBL[r][7:0]);
            clear_all();
        end

        // R7 vector read clears the winner, next one appears
        mask = 3'd0;
        pulse(8'h06);
        vrd = 1'b1;
        chk("R7 read vec", vec, 8'h44);
        step(); vrd = 1'b0;
        chk("R7 next vec", vec, 8'h48);
        vrd = 1'b1; step(); vrd = 1'b0;
        chk("R7 empty", {7'd0, irq}, 8'd0);

        // R10 edge and read clear in the same cycle
        pulse(8'h02);
        vrd = 1'b1; src = 8'h02;
        step(); vrd = 1'b0;
        chk("R10 kept", vec, 8'h44);
        src = '0; step();
        clear_all();

        // R9 software clear, R8 held-high input
        src = 8'h20; step();
        chk("R8 edge sets", vec, 8'h54);
        c_en = 1'b1; c_idx = 3'd5; step(); c_en = 1'b0;
        step();
        chk("R9 cleared / R8 held high", {7'd0, irq}, 8'd0);
        src = '0; step();

        // R2 reprogram to level 7 disables a pending source
        pulse(8'h01);
        chk("R2 before", vec, 8'h40);
        wr_lvl(0, 3'd7);
        chk("R2 level 7 off", {7'd0, irq}, 8'd0);
        clear_all();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule